// File: doc/BRIEF.md
# Start-Gap Wear-Leveling Address Remapper

This block spreads write wear across one region of a memory whose cells tolerate a limited number of writes. The region has `LINES` logical lines stored in `LINES + 1` physical lines. One physical line is always empty: this is the gap. The mapping from logical to physical lines is computed from two registers, a rotation offset and the gap position. No translation table is kept.

Each accepted host request leaves the block one cycle later as a single memory command with its physical line number. After every `WRITES_PER_MOVE` accepted host writes, the block migrates the gap down by one line. It emits a copy-read of the line just below the gap, then a copy-write into the gap line. The line that was read becomes the new gap. When the gap sits at line 0, the next move copies the top physical line into line 0. The gap then returns to the top line and the rotation offset advances by one. Host requests are refused while a move is in progress. The memory that executes the commands and holds the copy data lies outside the block.

Top module: `sg_remap`

## Requirements
- R1: After synchronous reset, `cmd_valid` is 0 and `req_ready` is 1. The rotation offset is 0 and the gap is physical line `LINES`, so logical line L first maps to physical line L.
- R2: A host request for logical line L gets physical line P = (offset + L) mod `LINES`. P is incremented by one when it is greater than or equal to the gap position.
- R3: Only accepted host writes advance the wear counter. The `WRITES_PER_MOVE`-th accepted write since the last move starts a gap move. Reads never start one.
- R4: A gap move puts two commands on consecutive cycles, directly after the triggering write's command. First comes kind 2 (copy-read) at the source line, then kind 3 (copy-write) at the gap line. When the gap is G > 0, the source is G-1 and the gap becomes G-1.
- R5: When the gap is 0, the copy-read source is line `LINES`, the copy-write target is line 0, the gap becomes `LINES`, and the offset increments modulo `LINES`.
- R6: `req_ready` is 0 in the two cycles that carry the triggering write's command and the copy-read. It is 1 again in the cycle that carries the copy-write. A request presented while `req_ready` is 0 is dropped and produces no command.
- R7: An accepted request produces exactly one command on the next cycle: kind 0 for a read, kind 1 for a write. `cmd_valid` is 0 in every cycle that carries no command.
- R8: Through any number of moves, a host read of logical line L reaches the physical line that holds the data last written to L.
- R9: A host command never addresses the current gap line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = host write, 0 = host read |
| req_laddr | input | $clog2(LINES) | Logical line number |
| req_ready | output | 1 | Request accepted this cycle when high |
| cmd_valid | output | 1 | Memory command present |
| cmd_kind | output | 2 | 0 host read, 1 host write, 2 copy-read, 3 copy-write |
| cmd_addr | output | $clog2(LINES)+1 | Physical line number |

## Verification
The bench holds writes on the request port across every move. A design that let a dropped request through, or released `req_ready` a cycle early or late, would show an extra command or a ready mismatch. Long write-only stretches drive the gap through line 0 many times. A design with a wrong wrap source, a missed offset step or an off-by-one gap compare would send a later host read to a stale line, which the bench's storage model catches as wrong data. Read-only stretches confirm that reads never trigger a move. Calls that hit every logical line after many rotations catch a translation that only goes wrong at the wrap of the modulo sum.

// File: rtl/sg_pkg.sv
package sg_pkg;

    typedef enum logic [1:0] {
        CMD_HOST_RD = 2'd0,
        CMD_HOST_WR = 2'd1,
        CMD_COPY_RD = 2'd2,
        CMD_COPY_WR = 2'd3
    } cmd_kind_e;

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_COPY_RD = 2'd1,
        SEQ_COPY_WR = 2'd2
    } seq_state_e;

    function automatic int unsigned ctr_width(int unsigned limit);
        return (limit > 1) ? $clog2(limit) : 1;
    endfunction

endpackage

// File: rtl/sg_translate.sv
module sg_translate #(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] laddr,
    input  logic [ADDR_W-1:0] offset,
    input  logic [ADDR_W:0]   gap,
    output logic [ADDR_W:0]   paddr
);
    logic [ADDR_W-1:0] rotated;
    logic [ADDR_W:0]   rotated_ext;

    always_comb begin
        rotated     = laddr + offset;
        rotated_ext = {1'b0, rotated};
        if (rotated_ext >= gap) begin
            paddr = rotated_ext + 1'b1;
        end else begin
            paddr = rotated_ext;
        end
    end
endmodule

// File: rtl/sg_wear_ctr.sv
module sg_wear_ctr #(
    parameter int WRITES_PER_MOVE = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_accept,
    output logic move_due
);
    import sg_pkg::*;

    localparam int CNT_W = ctr_width(WRITES_PER_MOVE);

    generate
        if (WRITES_PER_MOVE <= 1) begin : g_every_write
            assign move_due = wr_accept;
        end else begin : g_counted
            localparam logic [CNT_W-1:0] LAST = CNT_W'(WRITES_PER_MOVE - 1);
            logic [CNT_W-1:0] count_q;

            assign move_due = wr_accept && (count_q == LAST);

            always_ff @(posedge clk) begin
                if (rst) begin
                    count_q <= '0;
                end else if (wr_accept) begin
                    if (count_q == LAST) begin
                        count_q <= '0;
                    end else begin
                        count_q <= count_q + 1'b1;
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/sg_gap_seq.sv
module sg_gap_seq #(
    parameter int LINES = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      move_due,
    output sg_pkg::seq_state_e        state,
    output logic [$clog2(LINES)-1:0]  offset,
    output logic [$clog2(LINES):0]    gap,
    output logic [$clog2(LINES):0]    src_line,
    output logic [$clog2(LINES):0]    dst_line
);
    import sg_pkg::*;

    localparam int ADDR_W = $clog2(LINES);
    localparam logic [ADDR_W:0] TOP_LINE = (ADDR_W+1)'(LINES);

    seq_state_e        state_q;
    logic [ADDR_W-1:0] offset_q;
    logic [ADDR_W:0]   gap_q;

    assign state    = state_q;
    assign offset   = offset_q;
    assign gap      = gap_q;
    assign dst_line = gap_q;
    assign src_line = (gap_q == '0) ? TOP_LINE : gap_q - 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SEQ_IDLE;
            offset_q <= '0;
            gap_q    <= TOP_LINE;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (move_due) begin
                        state_q <= SEQ_COPY_RD;
                    end
                end
                SEQ_COPY_RD: begin
                    state_q <= SEQ_COPY_WR;
                end
                SEQ_COPY_WR: begin
                    state_q <= SEQ_IDLE;
                    if (gap_q == '0) begin
                        gap_q    <= TOP_LINE;
                        offset_q <= offset_q + 1'b1;
                    end else begin
                        gap_q <= gap_q - 1'b1;
                    end
                end
                default: begin
                    state_q <= SEQ_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/sg_remap.sv
module sg_remap #(
    parameter int LINES           = 16,
    parameter int WRITES_PER_MOVE = 100
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [$clog2(LINES)-1:0]  req_laddr,
    output logic                      req_ready,
    output logic                      cmd_valid,
    output logic [1:0]                cmd_kind,
    output logic [$clog2(LINES):0]    cmd_addr
);
    import sg_pkg::*;

    localparam int ADDR_W = $clog2(LINES);

    seq_state_e        state_w;
    logic [ADDR_W-1:0] start_q;
    logic [ADDR_W:0]   gap_q;
    logic [ADDR_W:0]   src_w;
    logic [ADDR_W:0]   dst_w;
    logic [ADDR_W:0]   host_paddr;
    logic              accept;
    logic              wr_accept;
    logic              move_due;

    cmd_kind_e         kind_q;
    logic              valid_q;
    logic [ADDR_W:0]   addr_q;

    assign req_ready = (state_w == SEQ_IDLE);
    assign accept    = req_valid && req_ready;
    assign wr_accept = accept && req_write;

    sg_translate #(.ADDR_W(ADDR_W)) u_xlate (
        .laddr  (req_laddr),
        .offset (start_q),
        .gap    (gap_q),
        .paddr  (host_paddr)
    );

    sg_wear_ctr #(.WRITES_PER_MOVE(WRITES_PER_MOVE)) u_wear (
        .clk       (clk),
        .rst       (rst),
        .wr_accept (wr_accept),
        .move_due  (move_due)
    );

    sg_gap_seq #(.LINES(LINES)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .move_due (move_due),
        .state    (state_w),
        .offset   (start_q),
        .gap      (gap_q),
        .src_line (src_w),
        .dst_line (dst_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            kind_q  <= CMD_HOST_RD;
            addr_q  <= '0;
        end else begin
            case (state_w)
                SEQ_COPY_RD: begin
                    valid_q <= 1'b1;
                    kind_q  <= CMD_COPY_RD;
                    addr_q  <= src_w;
                end
                SEQ_COPY_WR: begin
                    valid_q <= 1'b1;
                    kind_q  <= CMD_COPY_WR;
                    addr_q  <= dst_w;
                end
                default: begin
                    valid_q <= accept;
                    kind_q  <= req_write ? CMD_HOST_WR : CMD_HOST_RD;
                    addr_q  <= host_paddr;
                end
            endcase
        end
    end

    assign cmd_valid = valid_q;
    assign cmd_kind  = kind_q;
    assign cmd_addr  = addr_q;
endmodule

// File: rtl/sg_remap_chk.sv
module sg_remap_chk #(
    parameter int LINES = 16
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      req_ready,
    input logic                      cmd_valid,
    input logic [1:0]                cmd_kind,
    input logic [$clog2(LINES):0]    cmd_addr,
    input logic [$clog2(LINES):0]    gap,
    input logic [$clog2(LINES)-1:0]  start
);
    localparam int ADDR_W = $clog2(LINES);
    localparam logic [ADDR_W:0] TOP_LINE = (ADDR_W+1)'(LINES);

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!cmd_valid && req_ready));

    p_copy_pair_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind == 2'd3) |->
            ($past(cmd_valid) && $past(cmd_kind) == 2'd2 &&
             $past(cmd_addr) == ((cmd_addr == '0) ? TOP_LINE : cmd_addr - 1'b1)));

    p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind == 2'd3 && cmd_addr == '0) |->
            (gap == TOP_LINE && start == ADDR_W'($past(start) + 1'b1)));

    p_gap_range_r5: assert property (@(posedge clk) disable iff (rst)
        gap <= TOP_LINE);

    p_stall_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind == 2'd2) |-> !req_ready);

    p_host_off_gap_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_kind[1]) |-> (cmd_addr != gap));
endmodule

bind sg_remap sg_remap_chk #(.LINES(LINES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .cmd_valid (cmd_valid),
    .cmd_kind  (cmd_kind),
    .cmd_addr  (cmd_addr),
    .gap       (gap_q),
    .start     (start_q)
);

// File: tb/sg_remap_test.sv
module sg_remap_test;
    localparam int N   = 8;
    localparam int PSI = 3;
    localparam int AW  = $clog2(N);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_laddr = '0;
    logic          req_ready;
    logic          cmd_valid;
    logic [1:0]    cmd_kind;
    logic [AW:0]   cmd_addr;

    sg_remap #(.LINES(N), .WRITES_PER_MOVE(PSI)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_laddr(req_laddr), .req_ready(req_ready), .cmd_valid(cmd_valid),
        .cmd_kind(cmd_kind), .cmd_addr(cmd_addr)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // inputs as seen at the last rising edge
    bit p_seen = 0, p_rst = 1, p_v = 0, p_w = 0;
    int p_la = 0;
    always @(posedge clk) begin
        p_seen <= 1;
        p_rst  <= rst;
        p_v    <= req_valid;
        p_w    <= req_write;
        p_la   <= int'(req_laddr);
    end

    // behavioural reference
    int m_state = 0, m_start = 0, m_gap = N, m_cnt = 0;
    int exp_v = 0, exp_k = 0, exp_a = 0, exp_la = 0;
    int mem[0:N];
    int shadow[0:N-1];
    int copy_buf = 0;
    int serial = 5000;

    function automatic int map_line(int la, int st, int gp);
        int r;
        r = (st + la) % N;
        if (r >= gp) r = r + 1;
        return r;
    endfunction

    task automatic check(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
        end
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            mem[i] = 1000 + i;
            shadow[i] = 1000 + i;
        end
        mem[N] = -1;
    end

    always @(negedge clk) begin
        if (p_seen) begin
            if (p_rst) begin
                m_state = 0; m_start = 0; m_gap = N; m_cnt = 0; exp_v = 0;
            end else begin
                exp_v = 0;
                case (m_state)
                    0: if (p_v) begin
                        exp_v  = 1;
                        exp_k  = p_w ? 1 : 0;
                        exp_la = p_la;
                        exp_a  = map_line(p_la, m_start, m_gap);
                        if (p_w) begin
                            if (m_cnt == PSI - 1) begin m_cnt = 0; m_state = 1; end
                            else m_cnt++;
                        end
                    end
                    1: begin
                        exp_v = 1; exp_k = 2;
                        exp_a = (m_gap == 0) ? N : m_gap - 1;
                        m_state = 2;
                    end
                    default: begin
                        exp_v = 1; exp_k = 3; exp_a = m_gap;
                        if (m_gap == 0) begin m_gap = N; m_start = (m_start + 1) % N; end
                        else m_gap--;
                        m_state = 0;
                    end
                endcase
            end
            // R6: ready follows the move phases
            check(req_ready === (m_state == 0), p_rst ? "R1" : "R6", int'(req_ready), int'(m_state == 0));
            if (p_rst || exp_v == 0) begin
                // R1 after reset, R7 no spurious command
                check(cmd_valid === 1'b0, p_rst ? "R1" : "R7", int'(cmd_valid), 0);
            end else begin
                check(cmd_valid === 1'b1 && int'(cmd_kind) == exp_k, "R7", int'(cmd_kind), exp_k);
                if (exp_k < 2) begin
                    check(int'(cmd_addr) == exp_a, "R2", int'(cmd_addr), exp_a);
                    // R9: a host command never lands on the gap line
                    check(int'(cmd_addr) != m_gap, "R9", int'(cmd_addr), m_gap);
                end else if (exp_k == 2) begin
                    check(int'(cmd_addr) == exp_a, "R3 R4", int'(cmd_addr), exp_a);
                end else begin
                    check(int'(cmd_addr) == exp_a, (exp_a == 0) ? "R5" : "R4", int'(cmd_addr), exp_a);
                end
                // storage model driven by the design's own commands
                if (cmd_valid === 1'b1 && int'(cmd_addr) <= N) begin
                    case (cmd_kind)
                        2'd0: check(mem[cmd_addr] == shadow[exp_la], "R8", mem[cmd_addr], shadow[exp_la]);
                        2'd1: begin
                            serial++;
                            mem[cmd_addr] = serial;
                            shadow[exp_la] = serial;
                        end
                        2'd2: copy_buf = mem[cmd_addr];
                        default: mem[cmd_addr] = copy_buf;
                    endcase
                end
            end
        end
    end

    task automatic drive(bit v, bit w, int la);
        @(negedge clk);
        #1;
        req_valid = v;
        req_write = w;
        req_laddr = AW'(la);
    endtask

    int lfsr = 32'h1ACE;
    function automatic int next_rand(int s);
        return (s >> 1) ^ ((s & 1) ? 32'hB400 : 0);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        // R1: identity map before any move; R3: reads alone never move the gap
        for (int i = 0; i < 40; i++) drive(1, 0, i % N);
        // exactly PSI-1 writes: still no move
        for (int i = 0; i < PSI - 1; i++) drive(1, 1, i);
        drive(0, 0, 0);
        drive(0, 0, 0);
        // held writes across moves exercise R6 stalls and dropped requests
        for (int i = 0; i < 300; i++) drive(1, 1, i % N);
        // R5: long write runs push the gap through line 0 repeatedly
        for (int i = 0; i < 400; i++) begin
            lfsr = next_rand(lfsr);
            drive(1, 1, lfsr % N);
        end
        // mixed traffic with idle gaps
        for (int i = 0; i < 600; i++) begin
            lfsr = next_rand(lfsr);
            drive((lfsr & 3) != 0, (lfsr & 8) != 0, (lfsr >> 4) % N);
        end
        // R8: sweep every logical line after many rotations
        for (int r = 0; r < 3; r++)
            for (int i = 0; i < N; i++) drive(1, 0, i);
        drive(0, 0, 0);
        repeat (4) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule